// File: doc/BRIEF.md
# Three-Source Heartbeat Chain Combiner

This block merges the liveness pulses of three independent processors into a single heartbeat for one downstream watchdog. Each processor toggles its own heartbeat line at its own rate, with no relation to the system clock. Every line passes through a two-flop synchronizer and a rising-edge detector. The detected edges then drive an ordered token chain of three stages. Stage 1 takes a token from heartbeat 1. Stage 2 passes it on only when heartbeat 2 rises. Stage 3 passes it on only when heartbeat 3 rises.

When the token reaches stage 3, the combined output pulses for exactly one clock and the chain clears, so that a new round can begin. If any one heartbeat stalls, the token stops at its stage and the combined output goes quiet. The downstream watchdog then sees this silence.

The chain is a state machine with four states:
- `CH_IDLE`: no stage holds the token.
- `CH_HAVE1`: stage 1 is set.
- `CH_HAVE2`: stages 1 and 2 are set.
- `CH_FIRE`: stage 3 is set and stages 1 and 2 have just been cleared.

It has five transitions:
- `CH_IDLE` to `CH_HAVE1` on a heartbeat-1 edge.
- `CH_HAVE1` to `CH_HAVE2` on a heartbeat-2 edge.
- `CH_HAVE2` to `CH_FIRE` on a heartbeat-3 edge.
- `CH_FIRE` to `CH_HAVE1` when a heartbeat-1 edge arrives during the pulse cycle.
- `CH_FIRE` to `CH_IDLE` otherwise.

In all other cases the state holds.

Top module: `beat_merge`

## Requirements
- R1: Reset drives `beat_out` low and empties the chain. After reset, a heartbeat-3 edge alone gives no pulse.
- R2: Each `beat_in` bit is synchronized through two flops, and only a low-to-high transition counts as an edge. A line that stays high gives no further advance. An edge that completes the chain raises `beat_out` after the third rising clock edge that follows the input change.
- R3: Stage 1 sets on a heartbeat-1 edge (bit 0 of `beat_in`) only while the NOR of stages 1 and 2 is true. A heartbeat-1 edge with the chain already holding a token is ignored.
- R4: Stage 2 sets on a heartbeat-2 edge (bit 1) only while stage 1 is set. Otherwise that edge is ignored.
- R5: Stage 3 sets on a heartbeat-3 edge (bit 2) only while stage 2 is set. Otherwise that edge is ignored.
- R6: Setting stage 3 drives `beat_out` high for exactly one clock and clears stages 1 and 2 in the same clock.
- R7: A heartbeat-1 edge arriving during the pulse cycle is accepted as the start of the next round.
- R8: Edges arriving in the same clock on several inputs advance the chain by at most one stage.
- R9: While any one heartbeat is stalled, `beat_out` produces no pulse.
- R10: With all three heartbeats running at periods P1, P2 and P3 clocks, the time between successive pulses is at least P3 and at most P1+P2+P3+3 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_in | input | 3 | Asynchronous heartbeats; bit 0 is heartbeat 1, bit 1 is heartbeat 2, bit 2 is heartbeat 3 |
| beat_out | output | 1 | Combined heartbeat, one-clock pulse per completed round |

## Verification
The bench applies edges out of order: heartbeat 2 or 3 with an empty chain, and heartbeat 1 or 3 while only stage 1 is set. A design that checked only its own input and not the stage before it would then fire early. Simultaneous edges on several lines are applied; a chain that cascades in one clock would pulse on a single combined event. A line held high is checked to see that it gives no second advance; a level-sensitive stage would re-arm without a new edge. A heartbeat-1 edge is placed exactly in the pulse cycle; a design that blocks stage 1 while stage 3 is set would lose that round. A reset is applied mid-chain and one input is held stalled; a design that keeps stale tokens, or that does not strictly require all three lines, would keep pulsing.

// File: rtl/beat_merge_pkg.sv
package beat_merge_pkg;

    localparam int NUM_HB = 3;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_HAVE1 = 2'd1,
        CH_HAVE2 = 2'd2,
        CH_FIRE  = 2'd3
    } chain_state_e;

endpackage

// File: rtl/beat_sync_edge.sv
module beat_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] shreg;
    logic         prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            prev_q <= 1'b0;
        end else begin
            shreg  <= {shreg[MSB-1:0], async_in};
            prev_q <= shreg[MSB];
        end
    end

    assign rise_o = shreg[MSB] & ~prev_q;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/beat_chain_fsm.sv
module beat_chain_fsm
    import beat_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HB-1:0] beat_rise,
    output logic              pulse_o
);
    chain_state_e state_q, state_d;
    logic stage1, stage2, chain_empty, take1;

    // stage flags as seen from the state
    assign stage1      = (state_q == CH_HAVE1) || (state_q == CH_HAVE2);
    assign stage2      = (state_q == CH_HAVE2);
    assign chain_empty = ~(stage1 | stage2);
    assign take1       = chain_empty & beat_rise[0];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (take1)        state_d = CH_HAVE1;
            CH_HAVE1: if (beat_rise[1]) state_d = CH_HAVE2;
            CH_HAVE2: if (beat_rise[2]) state_d = CH_FIRE;
            CH_FIRE:  state_d = take1 ? CH_HAVE1 : CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == CH_FIRE);
    end

    // R3
    stage1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_HAVE1) |-> $past(beat_rise[0]));
    // R4
    stage2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_HAVE2) |-> $past(beat_rise[1]) && $past(state_q == CH_HAVE1));
    // R5
    stage3_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(beat_rise[2]) && $past(state_q == CH_HAVE2));
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R8
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |=> (state_q == CH_IDLE) || (state_q == CH_HAVE1));

endmodule

// File: rtl/beat_merge.sv
module beat_merge
    import beat_merge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HB-1:0] beat_in,
    output logic              beat_out
);
    logic [NUM_HB-1:0] rise;

    for (genvar g = 0; g < NUM_HB; g++) begin : g_sync
        beat_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (beat_in[g]),
            .rise_o   (rise[g])
        );
    end

    beat_chain_fsm u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_rise (rise),
        .pulse_o   (beat_out)
    );

endmodule

// File: tb/test_beat_merge.sv
module test_beat_merge;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] beat_in = 3'b000;
    logic       beat_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    beat_merge i_beat_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_in  (beat_in),
        .beat_out (beat_out)
    );

    // {expected beat_out, beat_in pattern}
    localparam logic [3:0] VEC_TAB [0:32] = '{
        4'b0_001, 4'b0_000, 4'b0_010, 4'b0_000, 4'b1_100, 4'b0_000, // R3 R4 R5 R6 ordered round
        4'b0_010, 4'b0_000, 4'b0_100, 4'b0_000,                     // R4 R5 ignored when empty
        4'b0_001, 4'b0_000, 4'b0_001, 4'b0_000, 4'b0_100, 4'b0_000, // R3 re-edge, R5 ignored
        4'b0_010, 4'b0_000, 4'b0_011, 4'b0_000, 4'b1_100, 4'b0_000, // R3 R4 ignored in stage 2
        4'b0_111, 4'b0_000, 4'b0_110, 4'b0_000, 4'b1_100, 4'b0_000, // R8 simultaneous edges
        4'b0_001, 4'b0_011, 4'b1_111, 4'b0_111, 4'b0_000            // R2 held levels
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the third posedge
    task automatic apply(input logic [2:0] pat, output logic got);
        beat_in = pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        got = beat_out;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic got;
        int   npulse;
        int   last;
        int   gap;
        logic prev_o;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset output", beat_out, 1'b0);
        rst_n = 1'b1;

        // R1: a heartbeat-3 edge alone after reset gives nothing
        apply(3'b100, got); chk("R1 empty after reset", got, 1'b0);
        apply(3'b000, got);

        for (int i = 0; i <= 32; i++) begin
            apply(VEC_TAB[i][2:0], got);
            chk($sformatf("vector %0d (R2/R3/R4/R5/R6/R8)", i), got, VEC_TAB[i][3]);
        end

        // R6: one clock wide pulse
        apply(3'b001, got); apply(3'b000, got);
        apply(3'b010, got); apply(3'b000, got);
        apply(3'b100, got); chk("R6 pulse high", got, 1'b1);
        @(negedge clk);     chk("R6 pulse one clock", beat_out, 1'b0);
        apply(3'b000, got);

        // R7: heartbeat-1 edge during the pulse cycle starts the next round
        apply(3'b001, got); apply(3'b000, got);
        apply(3'b010, got); apply(3'b000, got);
        beat_in = 3'b100;
        @(negedge clk);
        beat_in = 3'b101;
        @(posedge clk); @(posedge clk);
        @(negedge clk);     chk("R7 pulse", beat_out, 1'b1);
        @(negedge clk);     chk("R7 pulse ends", beat_out, 1'b0);
        apply(3'b000, got);
        apply(3'b010, got); chk("R7 stage 2 from kept token", got, 1'b0);
        apply(3'b000, got);
        apply(3'b100, got); chk("R7 round completes", got, 1'b1);
        apply(3'b000, got);

        // R1: reset in mid-chain empties it
        apply(3'b001, got); apply(3'b000, got);
        apply(3'b010, got); apply(3'b000, got);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 output in reset", beat_out, 1'b0);
        rst_n = 1'b1;
        apply(3'b100, got); chk("R1 token dropped", got, 1'b0);
        apply(3'b000, got);
        apply(3'b010, got); chk("R1 R4 stage 2 needs stage 1", got, 1'b0);
        apply(3'b000, got);
        apply(3'b001, got); apply(3'b000, got);
        apply(3'b010, got); apply(3'b000, got);
        apply(3'b100, got); chk("R1 full round after reset", got, 1'b1);
        apply(3'b000, got);

        // R9: heartbeat 2 stalled
        npulse = 0;
        for (int c = 0; c < 400; c++) begin
            beat_in = {((c % 22) < 11), 1'b0, ((c % 10) < 5)};
            @(negedge clk);
            if (beat_out) npulse++;
        end
        chk("R9 stalled heartbeat pulses", (npulse == 0), 1'b1);

        // R10: all running, periods 10 / 14 / 22 clocks
        npulse = 0;
        last   = -1;
        prev_o = 1'b0;
        for (int c = 0; c < 1200; c++) begin
            beat_in = {((c % 22) < 11), ((c % 14) < 7), ((c % 10) < 5)};
            @(negedge clk);
            if (beat_out && prev_o)
                chk("R6 pulse width while running", 1'b0, 1'b1);
            if (beat_out) begin
                npulse++;
                if (last >= 0) begin
                    gap = c - last;
                    chk($sformatf("R10 gap %0d >= 22", gap), (gap >= 22), 1'b1);
                    chk($sformatf("R10 gap %0d <= 49", gap), (gap <= 49), 1'b1);
                end
                last = c;
            end
            prev_o = beat_out;
        end
        chk("R10 pulses produced", (npulse >= 10), 1'b1);

        summary();
        $finish;
    end

endmodule